// File: doc/BRIEF.md
# MMU and Exception Control Register File

This block holds the register state that a processor core's memory-management unit and exception logic share with software. It stores the MMU control word, the page-table-entry high, low and assist words, the translation table base, the faulting address, the trap code, and the exception and interrupt event codes. Three read-only identification words give the processor version, the cache version and the processor revision. Each writable register masks its write data down to the fields it actually holds.

Two kinds of write also send a one-cycle command to a neighbouring TLB. Setting the invalidate bit in the MMU control word requests a full invalidate; that bit is never stored. A write to the page-table-entry high word that changes its address-space identifier requests a flush. The TLB itself lives outside this block.

The block only accepts 32-bit accesses to known, aligned offsets. Any other access is refused: it writes nothing, a read returns zero, and a sticky error flag is raised that only reset clears.

Top module: `mmuexc_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, every writable register reads 0, and `err_o`, `tlb_inv_o`, `tlb_flush_o` and `rd_valid_o` are 0.
- R2: Writable registers sit at byte offsets MMU control 0x00, entry-high 0x04, entry-low 0x08, table base 0x0C, fault address 0x10, trap code 0x14, exception event 0x18, interrupt event 0x1C, entry-assist 0x20; entry-low, table base and fault address store and return all 32 bits.
- R3: A word write to MMU control with bit 2 set makes `tlb_inv_o` high for exactly the one cycle after the write; bit 2 always reads 0 and the other 31 bits are stored as written.
- R4: A word write to entry-high whose bits [7:0] differ from the stored bits [7:0] makes `tlb_flush_o` high for exactly the one cycle after the write; a write with equal bits [7:0] gives no flush; all 32 bits are stored.
- R5: The entry-assist register keeps only write data bits [3:0]; bits [31:4] read 0.
- R6: The trap code, exception event and interrupt event registers keep only write data bits [10:0]; bits [31:11] read 0.
- R7: Offsets 0x30, 0x40 and 0x44 return the processor version, cache version and processor revision parameters; a write to any of them is illegal and leaves the value unchanged.
- R8: An access with `req_size` other than 2'b10 (32-bit) is illegal: it changes no register and a read returns 0.
- R9: An access to any offset not listed in R2 or R7, including misaligned ones, is illegal: it changes no register and a read returns 0.
- R10: `err_o` goes high in the cycle after the first illegal access and stays high through later legal accesses until reset.
- R11: Every read request produces `rd_valid_o` high, with the read data on `rd_data_o`, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | 32 | Read data |
| tlb_inv_o | output | 1 | One-cycle TLB invalidate command |
| tlb_flush_o | output | 1 | One-cycle TLB flush command |
| err_o | output | 1 | Sticky illegal-access flag |

## Verification
All-ones write data shows which fields each register keeps, and it separates the 4-bit, 11-bit, invalidate-masked and full-width registers from one another. Sparse patterns such as 0x1234 and 0x0FFFF800 check that a field mask cuts at the right bit rather than only clearing high bytes. Entry-high writes that alternate between a changed and an unchanged low byte show that the flush follows the identifier comparison rather than any write. Byte-sized, misaligned, unmapped and read-only-target accesses each come before and after legal traffic, so the refusal, the zero read data and the stickiness of the error flag can each be seen on its own.

// File: rtl/mmuexc_pkg.sv
// Package: shared constants and helper functions for the MMU/exception
// register file. Assumes 32-bit registers at word-aligned byte offsets.
package mmuexc_pkg;
    localparam int DATA_W = 32;
    localparam int NUM_RW = 9;
    localparam int NUM_RO = 3;
    localparam int EVT_W  = 11;
    localparam int AST_W  = 4;

    localparam int IX_MCTL  = 0;
    localparam int IX_PTEH  = 1;
    localparam int IX_PTEL  = 2;
    localparam int IX_TTB   = 3;
    localparam int IX_FAULT = 4;
    localparam int IX_TRAP  = 5;
    localparam int IX_EXPEV = 6;
    localparam int IX_INTEV = 7;
    localparam int IX_PTEA  = 8;

    localparam logic [1:0] SZ_WORD = 2'b10;

    // Byte offset of writable register idx: packed words from zero.
    function automatic logic [7:0] rw_offset(input int idx);
        return 8'(idx * 4);
    endfunction

    // Byte offset of read-only identification word k (fixed positions).
    function automatic logic [7:0] ro_offset(input int k);
        case (k)
            0:       return 8'h30;
            1:       return 8'h40;
            default: return 8'h44;
        endcase
    endfunction

    // Bits that writable register idx retains from write data.
    function automatic logic [DATA_W-1:0] keep_mask(input int idx, input int inv_bit);
        case (idx)
            IX_MCTL:                     return ~(DATA_W'(1) << inv_bit);
            IX_PTEA:                     return DATA_W'((1 << AST_W) - 1);
            IX_TRAP, IX_EXPEV, IX_INTEV: return DATA_W'((1 << EVT_W) - 1);
            default:                     return '1;
        endcase
    endfunction
endpackage

// File: rtl/mmuexc_decode.sv
// Decoder: turns an access request into one-hot register selects and an
// illegal flag. Assumes the request is held for exactly one cycle.
module mmuexc_decode
    import mmuexc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic [NUM_RW-1:0] rw_sel,
    output logic [NUM_RO-1:0] ro_sel,
    output logic              bad
);
    logic [NUM_RW-1:0] rw_hit;
    logic [NUM_RO-1:0] ro_hit;
    logic              size_ok;

    // Address match for each writable register.
    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw_hit
        assign rw_hit[g] = (req_addr == ADDR_W'(rw_offset(g)));
    end

    // Address match for each identification word.
    for (genvar g = 0; g < NUM_RO; g++) begin : g_ro_hit
        assign ro_hit[g] = (req_addr == ADDR_W'(ro_offset(g)));
    end

    // Qualify selects and classify illegal accesses.
    always_comb begin
        size_ok = (req_size == SZ_WORD);
        rw_sel  = (req_valid && size_ok) ? rw_hit : '0;
        ro_sel  = (req_valid && size_ok && !req_write) ? ro_hit : '0;
        bad     = req_valid && (!size_ok || !(|rw_hit || |ro_hit) || (req_write && |ro_hit));
    end

    // R9: at most one register is ever selected.
    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rw_sel, ro_sel}));

    // R8: a refused access selects nothing.
    p_bad_no_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> (rw_sel == '0 && ro_sel == '0));
endmodule

// File: rtl/mmuexc_regfile.sv
// Register storage: masks write data per register and raises the TLB
// invalidate and flush commands one cycle after the triggering write.
// Assumes rw_sel is one-hot or zero.
module mmuexc_regfile
    import mmuexc_pkg::*;
#(
    parameter int INV_BIT = 2,
    parameter int ASID_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [NUM_RW-1:0]             rw_sel,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_RW-1:0][DATA_W-1:0] regs,
    output logic                          inv_o,
    output logic                          flush_o
);
    // One storage register per writable slot, masked at write time.
    for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
        localparam logic [DATA_W-1:0] KEEP = keep_mask(g, INV_BIT);
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && rw_sel[g])
                regs[g] <= wdata & KEEP;
        end
    end

    // Side-effect commands, high for the cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_o   <= 1'b0;
            flush_o <= 1'b0;
        end else begin
            inv_o   <= wr_en && rw_sel[IX_MCTL] && wdata[INV_BIT];
            flush_o <= wr_en && rw_sel[IX_PTEH] &&
                       (wdata[ASID_W-1:0] != regs[IX_PTEH][ASID_W-1:0]);
        end
    end

    // R4: a flush always coincides with a changed identifier.
    p_flush_asid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (regs[IX_PTEH][ASID_W-1:0] != $past(regs[IX_PTEH][ASID_W-1:0])));

    // R3: an invalidate follows a write to the control word.
    p_inv_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_o |-> $past(wr_en && rw_sel[IX_MCTL]));
endmodule

// File: rtl/mmuexc_readmux.sv
// Read path: registers the selected word, or zero for a refused read,
// with a valid strobe one cycle after the request.
module mmuexc_readmux
    import mmuexc_pkg::*;
#(
    parameter logic [DATA_W-1:0] CPU_VER   = 32'h0405_0001,
    parameter logic [DATA_W-1:0] CACHE_VER = 32'h2080_0500,
    parameter logic [DATA_W-1:0] CPU_REV   = 32'h0000_0071
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic                          bad,
    input  logic [NUM_RW-1:0]             rw_sel,
    input  logic [NUM_RO-1:0]             ro_sel,
    input  logic [NUM_RW-1:0][DATA_W-1:0] regs,
    output logic                          rd_valid_o,
    output logic [DATA_W-1:0]             rd_data_o
);
    localparam logic [NUM_RO-1:0][DATA_W-1:0] RO_VALS = {CPU_REV, CACHE_VER, CPU_VER};

    logic [DATA_W-1:0] mux;

    // OR-combine the selected register and identification words.
    always_comb begin
        mux = '0;
        for (int i = 0; i < NUM_RW; i++)
            if (rw_sel[i]) mux = mux | regs[i];
        for (int k = 0; k < NUM_RO; k++)
            if (ro_sel[k]) mux = mux | RO_VALS[k];
    end

    // Capture read data and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en;
            if (rd_en)
                rd_data_o <= bad ? '0 : mux;
        end
    end

    // R6: event code reads never carry bits above the 11-bit field.
    p_event_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && $past(rd_en && (rw_sel[IX_TRAP] || rw_sel[IX_EXPEV] || rw_sel[IX_INTEV])))
        |-> (rd_data_o[DATA_W-1:EVT_W] == '0));

    // R5: assist reads carry only the 4-bit field.
    p_assist_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && $past(rd_en && rw_sel[IX_PTEA])) |-> (rd_data_o[DATA_W-1:AST_W] == '0));
endmodule

// File: rtl/mmuexc_ctrl_regs.sv
// Top: MMU and exception control register file. Decodes 32-bit accesses,
// stores masked register fields, drives one-cycle TLB invalidate/flush
// commands and keeps a sticky illegal-access flag. Synchronous reset.
module mmuexc_ctrl_regs
    import mmuexc_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                INV_BIT   = 2,
    parameter int                ASID_W    = 8,
    parameter logic [DATA_W-1:0] CPU_VER   = 32'h0405_0001,
    parameter logic [DATA_W-1:0] CACHE_VER = 32'h2080_0500,
    parameter logic [DATA_W-1:0] CPU_REV   = 32'h0000_0071
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o,
    output logic              tlb_inv_o,
    output logic              tlb_flush_o,
    output logic              err_o
);
    logic [NUM_RW-1:0]             rw_sel;
    logic [NUM_RO-1:0]             ro_sel;
    logic                          acc_bad;
    logic [NUM_RW-1:0][DATA_W-1:0] regs;

    mmuexc_decode #(.ADDR_W(ADDR_W)) i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .rw_sel    (rw_sel),
        .ro_sel    (ro_sel),
        .bad       (acc_bad)
    );

    mmuexc_regfile #(.INV_BIT(INV_BIT), .ASID_W(ASID_W)) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_valid && req_write),
        .rw_sel  (rw_sel),
        .wdata   (req_wdata),
        .regs    (regs),
        .inv_o   (tlb_inv_o),
        .flush_o (tlb_flush_o)
    );

    mmuexc_readmux #(.CPU_VER(CPU_VER), .CACHE_VER(CACHE_VER), .CPU_REV(CPU_REV)) i_readmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (req_valid && !req_write),
        .bad        (acc_bad),
        .rw_sel     (rw_sel),
        .ro_sel     (ro_sel),
        .regs       (regs),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (acc_bad)
            err_o <= 1'b1;
    end

    // R10: once set, the error flag holds.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R10: an illegal access raises the flag on the next cycle.
    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_bad && rst_n) |-> err_o);

    // R3: invalidate only after a word write to offset 0x00 with bit INV_BIT set.
    p_inv_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inv_o |-> $past(req_valid && req_write && req_size == SZ_WORD &&
                            req_addr == ADDR_W'(rw_offset(IX_MCTL)) && req_wdata[INV_BIT]));

    // R4: flush only after a word write to the entry-high offset.
    p_flush_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_o |-> $past(req_valid && req_write && req_size == SZ_WORD &&
                              req_addr == ADDR_W'(rw_offset(IX_PTEH))));

    // R3: the invalidate bit never reads back as 1.
    p_inv_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && $past(req_addr == ADDR_W'(rw_offset(IX_MCTL)))) |-> !rd_data_o[INV_BIT]);

    // R8: a read of the wrong size returns zero.
    p_bad_size_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && $past(req_size != SZ_WORD)) |-> (rd_data_o == '0));

    // R11: read data valid follows each read request by one cycle.
    p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid_o);
endmodule

// File: tb/test_mmuexc_ctrl_regs.sv
// Scoreboard bench: the access task queues expected read data, a monitor
// pops and compares when rd_valid_o appears.
module test_mmuexc_ctrl_regs;
    localparam logic [31:0] V_CPU   = 32'h0405_0001;
    localparam logic [31:0] V_CACHE = 32'h2080_0500;
    localparam logic [31:0] V_REV   = 32'h0000_0071;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        rd_valid_o, tlb_inv_o, tlb_flush_o, err_o;
    logic [31:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    logic saw_inv, saw_flush;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    mmuexc_ctrl_regs #(.CPU_VER(V_CPU), .CACHE_VER(V_CACHE), .CPU_REV(V_REV)) i_mmuexc_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .tlb_inv_o(tlb_inv_o),
        .tlb_flush_o(tlb_flush_o), .err_o(err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle access; reads queue their expected data.
    task automatic access(input logic wr, input logic [7:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag, input logic [31:0] exp_rd);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        if (!wr) begin
            exp_q.push_back(exp_rd);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        saw_inv = tlb_inv_o;
        saw_flush = tlb_flush_o;
    endtask

    task automatic wr32(input logic [7:0] addr, input logic [31:0] wd);
        access(1'b1, addr, 2'b10, wd, "", '0);
    endtask

    task automatic rd32(input logic [7:0] addr, input string tag, input logic [31:0] exp);
        access(1'b0, addr, 2'b10, '0, tag, exp);
    endtask

    // Monitor: compare each read result against the queue head.
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R11 unexpected read data actual=%h expected=none", rd_data_o);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rd_data_o, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of flags and registers
        check("R1 err after reset", {31'b0, err_o}, 32'h0);
        check("R1 inv after reset", {31'b0, tlb_inv_o}, 32'h0);
        check("R1 flush after reset", {31'b0, tlb_flush_o}, 32'h0);
        check("R1 rd_valid after reset", {31'b0, rd_valid_o}, 32'h0);
        for (int i = 0; i < 9; i++) rd32(8'(i * 4), "R1 register zero after reset", 32'h0);

        // R2: full-width registers
        wr32(8'h08, 32'hDEAD_BEEF);
        wr32(8'h0C, 32'h1234_5678);
        wr32(8'h10, 32'hFFFF_FFFF);
        rd32(8'h08, "R2 entry-low", 32'hDEAD_BEEF);
        rd32(8'h0C, "R2 table base", 32'h1234_5678);
        rd32(8'h10, "R2 fault address", 32'hFFFF_FFFF);

        // R3: self-clearing invalidate bit
        wr32(8'h00, 32'hFFFF_FFFF);
        check("R3 invalidate pulse", {31'b0, saw_inv}, 32'h1);
        @(negedge clk);
        check("R3 invalidate one cycle", {31'b0, tlb_inv_o}, 32'h0);
        rd32(8'h00, "R3 control readback", 32'hFFFF_FFFB);
        wr32(8'h00, 32'h0000_0001);
        check("R3 no invalidate without bit", {31'b0, saw_inv}, 32'h0);
        rd32(8'h00, "R3 control plain", 32'h0000_0001);

        // R4: identifier change flush
        wr32(8'h04, 32'h0000_1234);
        check("R4 flush on change", {31'b0, saw_flush}, 32'h1);
        @(negedge clk);
        check("R4 flush one cycle", {31'b0, tlb_flush_o}, 32'h0);
        wr32(8'h04, 32'hABCD_0034);
        check("R4 no flush same id", {31'b0, saw_flush}, 32'h0);
        rd32(8'h04, "R4 entry-high readback", 32'hABCD_0034);
        wr32(8'h04, 32'hABCD_0035);
        check("R4 flush low bit change", {31'b0, saw_flush}, 32'h1);

        // R5 and R6: field masks
        wr32(8'h20, 32'hFFFF_FFFF);
        rd32(8'h20, "R5 assist four bits", 32'h0000_000F);
        wr32(8'h14, 32'hFFFF_FFFF);
        wr32(8'h18, 32'h0000_1234);
        wr32(8'h1C, 32'h0FFF_F800);
        rd32(8'h14, "R6 trap code", 32'h0000_07FF);
        rd32(8'h18, "R6 exception event", 32'h0000_0234);
        rd32(8'h1C, "R6 interrupt event", 32'h0000_0000);

        // R7: identification words, still no error
        rd32(8'h30, "R7 processor version", V_CPU);
        rd32(8'h40, "R7 cache version", V_CACHE);
        rd32(8'h44, "R7 processor revision", V_REV);
        check("R10 no error before illegal", {31'b0, err_o}, 32'h0);
        wr32(8'h30, 32'h0);
        check("R10 error after write to version", {31'b0, err_o}, 32'h1);
        rd32(8'h30, "R7 version unchanged", V_CPU);

        // R8: wrong sizes
        access(1'b0, 8'h08, 2'b00, '0, "R8 byte read zero", 32'h0);
        access(1'b1, 8'h08, 2'b00, 32'h1111_1111, "", '0);
        access(1'b1, 8'h08, 2'b01, 32'h2222_2222, "", '0);
        rd32(8'h08, "R8 entry-low unchanged", 32'hDEAD_BEEF);

        // R9: unknown and misaligned offsets
        rd32(8'h24, "R9 unmapped read zero", 32'h0);
        rd32(8'h0A, "R9 misaligned read zero", 32'h0);
        wr32(8'h0E, 32'h5555_5555);
        rd32(8'h0C, "R9 table base unchanged", 32'h1234_5678);

        // R10: stickiness across legal traffic
        repeat (3) @(negedge clk);
        check("R10 error sticky", {31'b0, err_o}, 32'h1);
        check("R11 queue drained", 32'(exp_q.size()), 32'h0);

        // R1: second reset clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 err cleared by reset", {31'b0, err_o}, 32'h0);
        rd32(8'h08, "R1 entry-low cleared", 32'h0);
        rd32(8'h14, "R1 trap cleared", 32'h0);
        repeat (3) @(negedge clk);
        check("R11 final queue drained", 32'(exp_q.size()), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule